// File: doc/BRIEF.md
# Guest Sleep and Wake Handshake Controller

This block sits between a host processor and a legacy guest processor and runs the guest's sleep and wake handshake. The guest reports that it has gone to sleep with a one-cycle pulse. The block then sets a sticky sleep flag. If interrupts are enabled, it raises a level interrupt to the host. In the same event it copies a keypad-interrupt control word into a host-side snapshot register. The host wakes the guest again by writing the wake bit of the control register. In that same write it acknowledges the sleep flag.

The host reaches three 16-bit registers over a simple synchronous register bus. The bus has an address, a write strobe, write data and registered read data, with one cycle of read latency. The registers are:

- address 0: the control/status word;
- address 1: the keypad control word, read/write;
- address 2: the keypad snapshot, read-only.

Address 3 reads as zero. A wake request goes to the guest only while the sleep flag is set. A write that clears the flag but does not request a wake is therefore harmless. A separate acknowledge followed by a wake request produces no wake.

Top module: `guest_sleep_ctl`

## Requirements
- R1: After synchronous reset every register reads 0, and `host_irq` and `guest_wake` are 0.
- R2: A write to address 0 with bit 0 = 1 while the sleep flag is 1 drives `guest_wake` high for exactly one cycle, starting on the clock edge that takes the write. Bit 0 always reads back 0.
- R3: Bit 1 of address 0 is the sleep flag. A `guest_sleep` pulse sets it. Writing 1 to bit 1 clears it. Writing 0 to bit 1 leaves it unchanged.
- R4: `host_irq` is registered and always equals the sleep flag ANDed with bit 15 (interrupt enable). It rises and falls on the same edge as the flag or the enable changes.
- R5: Bits 3 to 14 of address 0 read as 0 whatever is written to them. Bit 2 is plain read/write storage, and bit 15 reads back the enable.
- R6: Address 1 is 16-bit read/write. On each `guest_sleep` pulse, address 2 takes the value address 1 held before that edge. Writes to address 2 are ignored.
- R7: A write with bit 1 = 1 and bit 0 = 0 clears the flag and generates no wake.
- R8: If a `guest_sleep` pulse and a write of 1 to bit 1 arrive in the same cycle, the flag ends up set.
- R9: A write of bit 0 = 1 while the flag is 0 produces no wake.
- R10: `rdata` is registered. It shows the register selected by `addr` one clock edge after `addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| guest_sleep | input | 1 | One-cycle pulse: guest entered sleep |
| guest_wake | output | 1 | One-cycle wake request to the guest |
| host_irq | output | 1 | Level interrupt to the host |

## Verification
The hardest situations to reach from the ports are these:
- a sleep pulse landing in the same cycle as a write that clears the flag;
- a wake or acknowledge write whose effect depends on whether the flag was set just before.

The bench sweeps every combination of the four meaningful control bits against both prior flag states, with noise in the unused bits, and predicts the wake, interrupt and readback arithmetically. It then drives the sleep pulse and an acknowledge write on the same cycle. It also changes the keypad word on the same edge as a sleep pulse, to show that the snapshot takes the earlier value.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned BIT_WAKE  = 0;
  localparam int unsigned BIT_FLAG  = 1;
  localparam int unsigned BIT_SPARE = 2;
  localparam int unsigned BIT_IEN   = REG_W - 1;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_KPAD = 2'd1;
  localparam logic [1:0] A_SNAP = 2'd2;
endpackage

// File: rtl/gsc_ctrl_reg.sv
module gsc_ctrl_reg
  import gsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctrl,
  input  logic [REG_W-1:0] wdata,
  input  logic             sleep_pulse,
  output logic             flag_o,
  output logic             ien_o,
  output logic             spare_o,
  output logic             wake_o,
  output logic             irq_o
);
  logic flag_q, ien_q, spare_q, wake_q, irq_q;
  logic flag_d, ien_d, spare_d, wake_d;

  always_comb begin
    flag_d  = flag_q;
    ien_d   = ien_q;
    spare_d = spare_q;
    wake_d  = 1'b0;
    if (wr_ctrl) begin
      ien_d   = wdata[BIT_IEN];
      spare_d = wdata[BIT_SPARE];
      wake_d  = wdata[BIT_WAKE] & flag_q;
      if (wdata[BIT_FLAG]) flag_d = 1'b0;
    end
    if (sleep_pulse) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      ien_q   <= 1'b0;
      spare_q <= 1'b0;
      wake_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      ien_q   <= ien_d;
      spare_q <= spare_d;
      wake_q  <= wake_d;
      irq_q   <= flag_d & ien_d;
    end
  end

  assign flag_o  = flag_q;
  assign ien_o   = ien_q;
  assign spare_o = spare_q;
  assign wake_o  = wake_q;
  assign irq_o   = irq_q;

  p_irq_tracks_r4: assert property (@(posedge clk) disable iff (rst)
    irq_q == (flag_q & ien_q));
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    sleep_pulse |=> flag_q);
  p_wake_gated_r9: assert property (@(posedge clk) disable iff (rst)
    wake_q |-> $past(flag_q));
  p_wake_from_write_r2: assert property (@(posedge clk) disable iff (rst)
    wake_q |-> $past(wr_ctrl));
  p_ack_no_wake_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && wdata[BIT_FLAG] && !wdata[BIT_WAKE]) |=> !wake_q);
endmodule

// File: rtl/gsc_keypad.sv
module gsc_keypad
  import gsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_kpad,
  input  logic [REG_W-1:0] wdata,
  input  logic             sleep_pulse,
  output logic [REG_W-1:0] kpad_o,
  output logic [REG_W-1:0] snap_o
);
  logic [REG_W-1:0] kpad_q, snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      kpad_q <= '0;
      snap_q <= '0;
    end else begin
      if (wr_kpad)     kpad_q <= wdata;
      if (sleep_pulse) snap_q <= kpad_q;
    end
  end

  assign kpad_o = kpad_q;
  assign snap_o = snap_q;

  p_snapshot_r6: assert property (@(posedge clk) disable iff (rst)
    sleep_pulse |=> snap_q == $past(kpad_q));
  p_snap_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !sleep_pulse |=> $stable(snap_q));
endmodule

// File: rtl/gsc_readmux.sv
module gsc_readmux
  import gsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] ctrl_word,
  input  logic [REG_W-1:0] kpad,
  input  logic [REG_W-1:0] snap,
  output logic [REG_W-1:0] rdata_o
);
  logic [REG_W-1:0] rd_d, rd_q;

  always_comb begin
    case (addr)
      A_CTRL:  rd_d = ctrl_word;
      A_KPAD:  rd_d = kpad;
      A_SNAP:  rd_d = snap;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_d;
  end

  assign rdata_o = rd_q;

  p_ctrl_unused_zero_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == A_CTRL) |-> (rd_q[BIT_IEN-1:BIT_SPARE+1] == '0 && !rd_q[BIT_WAKE]));
endmodule

// File: rtl/guest_sleep_ctl.sv
module guest_sleep_ctl
  import gsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             guest_sleep,
  output logic             guest_wake,
  output logic             host_irq
);
  logic wr_ctrl, wr_kpad;
  logic flag, ien, spare;
  logic [REG_W-1:0] kpad, snap, ctrl_word;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_kpad = wr_en && (addr == A_KPAD);

  gsc_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wdata(wdata),
    .sleep_pulse(guest_sleep), .flag_o(flag), .ien_o(ien),
    .spare_o(spare), .wake_o(guest_wake), .irq_o(host_irq)
  );

  gsc_keypad u_kpad (
    .clk(clk), .rst(rst), .wr_kpad(wr_kpad), .wdata(wdata),
    .sleep_pulse(guest_sleep), .kpad_o(kpad), .snap_o(snap)
  );

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[BIT_FLAG]  = flag;
    ctrl_word[BIT_SPARE] = spare;
    ctrl_word[BIT_IEN]   = ien;
  end

  gsc_readmux u_rd (
    .clk(clk), .rst(rst), .addr(addr), .ctrl_word(ctrl_word),
    .kpad(kpad), .snap(snap), .rdata_o(rdata)
  );

  p_wake_single_r2: assert property (@(posedge clk) disable iff (rst)
    guest_wake |=> !guest_wake || $past(wr_ctrl));
endmodule

// File: tb/sim_guest_sleep_ctl.sv
`timescale 1ns/1ps
module sim_guest_sleep_ctl;
  logic clk = 0, rst = 1, wr_en = 0, guest_sleep = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic guest_wake, host_irq;
  int checks = 0, errors = 0;
  logic [15:0] rv;

  always #5 clk = ~clk;

  guest_sleep_ctl u0 (.clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .guest_sleep(guest_sleep), .guest_wake(guest_wake), .host_irq(host_irq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic slp = 0);
    addr = a; wdata = d; wr_en = 1; guest_sleep = slp;
    @(negedge clk);
    wr_en = 0; guest_sleep = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic pulse();
    guest_sleep = 1;
    @(negedge clk);
    guest_sleep = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq", {15'd0, host_irq}, 16'd0);
    chk("R1 wake", {15'd0, guest_wake}, 16'd0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], rv);
      chk("R1 reg", rv, 16'd0);
    end

    // Sweep: prior flag x control bits {0,1,2,15}, noise in bits 3..14
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 16; p++) begin
        logic [15:0] w, exp_rd;
        logic ef, ew;
        wr(2'd0, 16'h0002);            // clear flag, no wake (R7)
        chk("R7 ack-only no wake", {15'd0, guest_wake}, 16'd0);
        if (s == 1) pulse();
        w = {p[3], 12'hABC, p[2], p[1], p[0]};
        ew = p[0] & (s == 1);
        ef = (s == 1) & !p[1];
        wr(2'd0, w);
        chk(ew ? "R2 wake pulse" : "R9 wake suppressed", {15'd0, guest_wake}, {15'd0, ew});
        chk("R4 irq", {15'd0, host_irq}, {15'd0, ef & p[3]});
        rd(2'd0, rv);
        exp_rd = {p[3], 12'd0, p[2], ef, 1'b0};
        chk("R5 readback", rv, exp_rd);
        chk("R2 wake one cycle", {15'd0, guest_wake}, 16'd0);
        chk("R3 flag", {15'd0, rv[1]}, {15'd0, ef});
      end
    end

    // R3: writing 0 to bit1 keeps flag; R4 irq rises with flag
    wr(2'd0, 16'h8002);
    pulse();
    chk("R4 irq rises", {15'd0, host_irq}, 16'd1);
    wr(2'd0, 16'h8000);
    rd(2'd0, rv);
    chk("R3 flag kept", rv, 16'h8002);
    wr(2'd0, 16'h8002);
    chk("R4 irq falls", {15'd0, host_irq}, 16'd0);

    // R8: sleep pulse and ack in the same cycle
    wr(2'd0, 16'h8002, 1'b1);
    rd(2'd0, rv);
    chk("R8 set wins", rv, 16'h8002);
    chk("R8 irq", {15'd0, host_irq}, 16'd1);

    // R6 keypad and snapshot
    for (int k = 0; k < 8; k++) begin
      logic [15:0] kv;
      kv = 16'h1357 * (k + 1) ^ (16'h8000 >> k);
      wr(2'd1, kv);
      rd(2'd1, rv);
      chk("R6 keypad rw", rv, kv);
      wr(2'd2, ~kv);
      rd(2'd2, rv);
      if (k > 0) chk("R6 snap write ignored", rv !== ~kv ? 16'd1 : 16'd0, 16'd1);
      pulse();
      rd(2'd2, rv);
      chk("R6 snapshot", rv, kv);
    end
    // R6: keypad written on same edge as pulse -> snapshot gets older value
    wr(2'd1, 16'h00F0);
    wr(2'd1, 16'h0F00, 1'b1);
    rd(2'd2, rv);
    chk("R6 old value", rv, 16'h00F0);
    rd(2'd1, rv);
    chk("R6 new keypad", rv, 16'h0F00);

    // R10 read latency: switch addr and sample after one edge
    addr = 2'd1;
    @(negedge clk);
    addr = 2'd3;
    @(negedge clk);
    chk("R10 latency", rdata, 16'd0);

    // R1 reset mid-run
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 irq after reset", {15'd0, host_irq}, 16'd0);
    rd(2'd2, rv);
    chk("R1 snap after reset", rv, 16'd0);
    rd(2'd0, rv);
    chk("R1 ctrl after reset", rv, 16'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule